// File: doc/BRIEF.md
# Power-Good Flag with Minimum Low Time

This block decides whether a dual-rail buck controller may report its outputs as good. Each monitored rail supplies two digital indications. One is a comparator bit that is set while the rail sits above its good threshold, roughly eleven percent under nominal. The other shows that the rail's soft start has finished. The block reports good only when every monitored rail shows both indications at once. No other supply in the system feeds the decision.

The output models an open-collector pin as a pull-low enable. A value of 1 means the pin is pulled low, so the outputs are not good. A value of 0 releases the pin, so the outputs are good. Any failing condition asserts the pull-low at once. A stretch counter then holds it for at least `HOLD_CYCLES` clock cycles, so a glitch of one cycle on the comparators still gives a clean, measurable low pulse. A new failure during the hold starts the window again. After reset the block behaves as though a failure had just occurred.

Top module: `pgood_flag`

## Requirements
- R1: The pin is released (`pg_pull_low` = 0) only when every bit of `rail_above` was 1 at the clock edge that releases it.
- R2: The pin is released only when every bit of `rail_ss_done` was 1 at the clock edge that releases it.
- R3: If any rail's comparator bit or soft-start bit is 0 at a clock edge, `pg_pull_low` is 1 after that edge.
- R4: After a failure sampled at edge k, `pg_pull_low` stays 1 through edge k+HOLD_CYCLES-1. If every edge from k+1 to k+HOLD_CYCLES sees all conditions good, the pin is released at edge k+HOLD_CYCLES.
- R5: A failure sampled while the hold window is running restarts the window from that failure's edge.
- R6: `pg_pull_low` is 1 while `rst_n` is 0. With all conditions good from reset release onward, the pin is released at the HOLD_CYCLES-th rising edge after `rst_n` rises.
- R7: The output encoding is 1 = pull the pin low (not good) and 0 = release the pin (good). Once released, it stays 0 for as long as all conditions stay good.
- R8: A failure that lasts a single clock edge still produces a low pulse of exactly HOLD_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_above | input | N_RAILS | Per-rail comparator: 1 = output above good threshold |
| rail_ss_done | input | N_RAILS | Per-rail soft-start complete: 1 = done |
| pg_pull_low | output | 1 | 1 = pull power-good pin low (not good), 0 = release (good) |

## Verification
On every cycle, the embedded assertions check four things:
- a release is always preceded by good comparator and soft-start bits on all rails;
- a failure always pulls the pin low on the next edge;
- the pin never releases while the hold counter is non-zero;
- the counter never leaves its range.

Some behaviours concern exact edge counts, so only the bench scenarios can show them. These are that release lands exactly HOLD_CYCLES edges after the last failure, that a repeated failure restarts the window, and that the first release after reset falls on the right edge. The bench covers these with a sweep over all sixteen input combinations of the two-rail configuration, each held for every duration from one cycle to past the hold window. It compares every cycle against an edge-index model.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  // Counter width able to hold values 0 .. hold-1 (at least one bit).
  function automatic int hold_cnt_w(input int hold);
    if (hold <= 2) return 1;
    return $clog2(hold);
  endfunction

  // Next value of the hold counter: reload on failure, count down otherwise.
  function automatic int unsigned hold_next(input int unsigned cur,
                                            input bit          cond_ok,
                                            input int unsigned reload);
    if (!cond_ok)  return reload;
    if (cur != 0)  return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/pgood_qualify.sv
module pgood_qualify #(
  parameter int N_RAILS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] above,
  input  logic [N_RAILS-1:0] ss_done,
  output logic               all_ok
);

  logic [N_RAILS-1:0] rail_ok;

  for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
    assign rail_ok[i] = above[i] & ss_done[i];
  end

  assign all_ok = &rail_ok;

  // A rail qualifies only when both its indications are present.
  AST_QUAL_NEEDS_SS: assert property (@(posedge clk) disable iff (!rst_n)
    all_ok |-> (&ss_done)); // R2
  AST_QUAL_NEEDS_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    all_ok |-> (&above)); // R1

endmodule

// File: rtl/pgood_hold.sv
module pgood_hold #(
  parameter int HOLD_CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_ok,
  output logic pull_low,
  output logic hold_busy
);

  localparam int CW = pgood_pkg::hold_cnt_w(HOLD_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] hold_cnt;
  logic [CW-1:0] hold_cnt_nxt;

  assign hold_cnt_nxt = CW'(pgood_pkg::hold_next(32'(hold_cnt), cond_ok, 32'(RELOAD)));
  assign hold_busy    = (hold_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= RELOAD;
      pull_low <= 1'b1;
    end else begin
      hold_cnt <= hold_cnt_nxt;
      pull_low <= !(cond_ok && !hold_busy);
    end
  end

  AST_FAIL_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> pull_low); // R3
  AST_HOLD_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> pull_low); // R4
  AST_RESTART_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_ok |=> (hold_cnt == RELOAD)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= RELOAD); // R4
  AST_RELEASE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pull_low && cond_ok) |=> !pull_low); // R7

endmodule

// File: rtl/pgood_flag.sv
module pgood_flag #(
  parameter int N_RAILS     = 2,
  parameter int HOLD_CYCLES = 500
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_RAILS-1:0] rail_above,
  input  logic [N_RAILS-1:0] rail_ss_done,
  output logic               pg_pull_low
);

  logic qual_ok;
  logic hold_busy;

  pgood_qualify #(.N_RAILS(N_RAILS)) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .above   (rail_above),
    .ss_done (rail_ss_done),
    .all_ok  (qual_ok)
  );

  pgood_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .cond_ok   (qual_ok),
    .pull_low  (pg_pull_low),
    .hold_busy (hold_busy)
  );

  AST_REL_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_pull_low) |-> $past(&rail_above)); // R1
  AST_REL_SS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_pull_low) |-> $past(&rail_ss_done)); // R2
  AST_REL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_pull_low) |-> !$past(hold_busy)); // R4

endmodule

// File: tb/tb_pgood_flag.sv
module tb_pgood_flag;

  localparam int NR = 2;
  localparam int M  = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] above = '0;
  logic [NR-1:0] ssd = '0;
  logic          pg_pull_low;

  int n_checks = 0;
  int n_errors = 0;
  int edge_idx = 0;
  int last_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pgood_flag #(.N_RAILS(NR), .HOLD_CYCLES(M)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rail_above   (above),
    .rail_ss_done (ssd),
    .pg_pull_low  (pg_pull_low)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: pg_pull_low=%0b expected %0b at edge %0d", tag, got, exp, edge_idx);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  // One clock: apply inputs, advance model by edge index, compare after the edge.
  task automatic step(input logic [NR-1:0] a, input logic [NR-1:0] s, input string tag);
    logic ok;
    logic exp;
    string t;
    above = a;
    ssd   = s;
    @(posedge clk);
    edge_idx++;
    ok = ((a & s) == {NR{1'b1}});
    if (!ok) last_fail = edge_idx;
    exp = !(ok && ((edge_idx - last_fail) >= M));
    #2;
    if (tag != "") t = tag;
    else if (!ok) t = "R3";
    else if ((edge_idx - last_fail) < M) t = "R4";
    else t = "R1 R2 R7";
    check(pg_pull_low, exp, t);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    above = '0;
    ssd   = '0;
    repeat (3) @(posedge clk);
    #2;
    check(pg_pull_low, 1'b1, "R6 reset");
    rst_n = 1'b1;
    edge_idx  = 0;
    last_fail = 0;
  endtask

  localparam logic [NR-1:0] ALL = {NR{1'b1}};

  initial begin
    do_reset();
    // R6: first release exactly at edge M after reset with all good.
    for (int i = 1; i <= M + 2; i++) step(ALL, ALL, (i == M) ? "R6 first release" : "");
    // R8: single-cycle glitch yields exactly M low cycles.
    step(2'b10, ALL, "R8 glitch");
    for (int i = 1; i <= M + 1; i++) step(ALL, ALL, "R8 stretch");
    // R5: a second failure inside the window restarts it.
    step(ALL, 2'b01, "R5 first fail");
    for (int i = 1; i < M - 1; i++) step(ALL, ALL, "R5");
    step(2'b01, ALL, "R5 refail");
    for (int i = 1; i <= M + 1; i++) step(ALL, ALL, "R5 restart");
    // R2: soft start incomplete blocks release even when above threshold.
    for (int i = 0; i < M + 3; i++) step(ALL, 2'b10, "R2 ss pending");
    for (int i = 0; i <= M; i++) step(ALL, ALL, "R2");
    // R1: comparator low blocks release even with soft start done.
    for (int i = 0; i < M + 3; i++) step(2'b01, ALL, "R1 below");
    for (int i = 0; i <= M; i++) step(ALL, ALL, "R1");
    // Sweep: every input combination held for every duration, then recovery.
    for (int p = 0; p < 16; p++) begin
      for (int len = 1; len <= M + 2; len++) begin
        for (int c = 0; c < len; c++) step(p[1:0], p[3:2], "");
        for (int c = 0; c <= M + 1; c++) step(ALL, ALL, "");
      end
    end
    // R6: reset mid-operation returns to low and restarts the window.
    do_reset();
    for (int i = 1; i <= M + 1; i++) step(ALL, ALL, "R6 after re-reset");
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

endmodule